// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block sits between a CPU and an on-chip flash array. The CPU hands it program and erase requests through a one-entry request buffer. The block moves each buffered request into an active slot and paces it with two counters. A prescaler divides the system clock into ticks. A start-delay counter then waits a programmable number of those ticks before a fixed-length operation phase of 8 ticks is signalled to the array. Status and the two timing values are kept in byte-wide registers on a simple CPU register bus.

Requests enter on a valid/ready port. `req_ready` is high whenever the buffer is empty, and a request is taken on any clock edge where `req_valid` and `req_ready` are both high. There is no back-pressure beyond that. A request presented while the buffer is full is not held: it is dropped and recorded in a sticky data-loss flag. While the flash is busy, a requester that presents a request also sees `cpu_hold`, so it can stall itself. An interrupt, gated by an enable bit, reports that the buffer can take a request.

Register map (`bus_addr`): 0 = control/status, 1 = prescaler, 2 = start delay, 3 = reads 0. Control/status bits: bit0 busy (read-only), bit1 buffer full (read-only), bit2 data-loss (write 1 to clear), bit3 interrupt enable (read/write), bits 7:4 read 0.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset the prescaler register reads 0x04, the start-delay register reads 0x18, the control/status register reads 0x00, `req_ready` is 1 and `fl_active` is 0.
- R2: `req_ready` equals the inverse of the buffer-full bit (control bit1). An accepted request sets that bit, and no request is accepted while it is set.
- R3: `irq` is high exactly when the interrupt enable (control bit3) is 1 and the buffer-full bit is 0.
- R4: A request presented while the buffer is full is dropped, and the data-loss bit (control bit2) is set on the next clock.
- R5: Writing 1 to control bit2 clears the data-loss bit. Writing 0 leaves it set. If an overrun occurs in the same cycle as a clearing write, the bit stays set.
- R6: `cpu_hold` is high in every cycle where `req_valid` is high and the flash is busy.
- R7: The prescaler register at address 1 keeps bits 4:0 as the divisor, and bits 7:5 read 0.
- R8: Writes to the prescaler and start-delay registers are ignored while busy (control bit0) is set.
- R9: Busy stays high for exactly (divisor+1)·(start+1+8) clock cycles. `fl_run` is high during the last 8·(divisor+1) of them.
- R10: When idle with the buffer full, the next clock sets busy, clears buffer-full, and shows the request's kind, address and data on `fl_erase`, `fl_addr` and `fl_data`.
- R11: A request buffered during an operation starts one clock after busy clears, so busy is low for exactly one cycle between the two operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Buffer can take a request |
| req_erase | input | 1 | 1 = erase, 0 = program |
| req_addr | input | 16 | Flash address of the request |
| req_data | input | 16 | Program data |
| cpu_hold | output | 1 | Stall for a requester while busy |
| irq | output | 1 | Buffer-ready interrupt |
| fl_active | output | 1 | Operation in progress (busy) |
| fl_run | output | 1 | Operation phase after the start delay |
| fl_erase | output | 1 | Kind of the active operation |
| fl_addr | output | 16 | Address of the active operation |
| fl_data | output | 16 | Data of the active operation |

## Verification
The bench measures the busy and run windows under random divisor and start values. A counter that reloads one tick early or late, or that ignores the divisor, would show up as an off-by-(divisor+1) busy length. It also drives a request into a full buffer while an operation runs. A design that queued the overrun instead of dropping it would start the wrong address next, and a design that let a clearing write beat a same-cycle overrun would lose the data-loss flag. Timing writes made during an operation are read back, so a design that does not lock the registers would return the new value. The bench also checks the one-cycle idle gap before a queued request starts, which catches a launch that overlaps the previous operation.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  parameter int FA_W  = 16;
  parameter int FD_W  = 16;
  parameter int BUS_W = 8;

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_PSC   = 2'd1;
  localparam logic [1:0] RA_DLY   = 2'd2;

  localparam int CB_BUSY = 0;
  localparam int CB_FULL = 1;
  localparam int CB_DERR = 2;
  localparam int CB_IEN  = 3;

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_OP} phase_t;

  typedef struct packed {
    logic            erase;
    logic [FA_W-1:0] addr;
    logic [FD_W-1:0] data;
  } freq_t;
endpackage

// File: rtl/fsc_regs.sv
module fsc_regs
  import flash_seq_pkg::*;
#(
  parameter int           DIV_W   = 5,
  parameter int           DLY_W   = 8,
  parameter logic [7:0]   DIV_RST = 8'h04,
  parameter logic [7:0]   DLY_RST = 8'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             busy,
  input  logic             buf_full,
  input  logic             overrun,
  output logic [DIV_W-1:0] div_q,
  output logic [DLY_W-1:0] dly_q,
  output logic             ien_q,
  output logic             derr_q
);
  logic wr_ctrl, wr_psc, wr_dly;

  assign wr_ctrl = bus_sel & bus_we & (bus_addr == RA_CTRL);
  assign wr_psc  = bus_sel & bus_we & (bus_addr == RA_PSC) & ~busy;
  assign wr_dly  = bus_sel & bus_we & (bus_addr == RA_DLY) & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_RST[DIV_W-1:0];
      dly_q  <= DLY_RST[DLY_W-1:0];
      ien_q  <= 1'b0;
      derr_q <= 1'b0;
    end else begin
      if (wr_psc) div_q <= bus_wdata[DIV_W-1:0];
      if (wr_dly) dly_q <= bus_wdata[DLY_W-1:0];
      if (wr_ctrl) ien_q <= bus_wdata[CB_IEN];
      // set has priority over a same-cycle clear
      if (overrun)
        derr_q <= 1'b1;
      else if (wr_ctrl && bus_wdata[CB_DERR])
        derr_q <= 1'b0;
    end
  end

  logic [BUS_W-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[CB_BUSY] = busy;
    ctrl_rd[CB_FULL] = buf_full;
    ctrl_rd[CB_DERR] = derr_q;
    ctrl_rd[CB_IEN]  = ien_q;
  end

  always_comb begin
    unique case (bus_addr)
      RA_CTRL: bus_rdata = ctrl_rd;
      RA_PSC:  bus_rdata = BUS_W'(div_q);
      RA_DLY:  bus_rdata = BUS_W'(dly_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fsc_reqbuf.sv
module fsc_reqbuf
  import flash_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  output logic  req_ready,
  input  freq_t req_in,
  input  logic  take,
  output logic  full,
  output logic  overrun,
  output freq_t head
);
  assign req_ready = ~full;
  assign overrun   = req_valid & full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      head <= '0;
    end else if (req_valid && req_ready) begin
      full <= 1'b1;
      head <= req_in;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/fsc_timer.sv
module fsc_timer
  import flash_seq_pkg::*;
#(
  parameter int DIV_W    = 5,
  parameter int DLY_W    = 8,
  parameter int OP_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DLY_W-1:0] dly_q,
  output logic             busy,
  output phase_t           phase
);
  localparam int OP_W  = (OP_TICKS > 1) ? $clog2(OP_TICKS) : 1;
  localparam int CNT_W = (DLY_W > OP_W) ? DLY_W : OP_W;

  logic [DIV_W-1:0] pre_cnt;
  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign busy = (phase != PH_IDLE);
  assign tick = busy && (pre_cnt == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      pre_cnt <= '0;
      cnt     <= '0;
    end else if (launch) begin
      phase   <= PH_START;
      pre_cnt <= '0;
      cnt     <= CNT_W'(dly_q);
    end else if (busy) begin
      pre_cnt <= tick ? '0 : pre_cnt + DIV_W'(1);
      if (tick) begin
        if (cnt != '0) begin
          cnt <= cnt - CNT_W'(1);
        end else if (phase == PH_START) begin
          phase <= PH_OP;
          cnt   <= CNT_W'(OP_TICKS - 1);
        end else begin
          phase <= PH_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int         DIV_W    = 5,
  parameter int         DLY_W    = 8,
  parameter int         OP_TICKS = 8,
  parameter logic [7:0] DIV_RST  = 8'h04,
  parameter logic [7:0] DLY_RST  = 8'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_erase,
  input  logic [FA_W-1:0]  req_addr,
  input  logic [FD_W-1:0]  req_data,
  output logic             cpu_hold,
  output logic             irq,
  output logic             fl_active,
  output logic             fl_run,
  output logic             fl_erase,
  output logic [FA_W-1:0]  fl_addr,
  output logic [FD_W-1:0]  fl_data
);
  logic             busy, buf_full, overrun, launch, ien_q, derr_q;
  logic [DIV_W-1:0] div_q;
  logic [DLY_W-1:0] dly_q;
  phase_t           phase;
  freq_t            req_in, head, act_q;

  assign req_in = '{erase: req_erase, addr: req_addr, data: req_data};
  assign launch = ~busy & buf_full;

  fsc_reqbuf u_buf (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_in(req_in), .take(launch), .full(buf_full), .overrun(overrun),
    .head(head)
  );

  fsc_regs #(.DIV_W(DIV_W), .DLY_W(DLY_W), .DIV_RST(DIV_RST), .DLY_RST(DLY_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .buf_full(buf_full), .overrun(overrun),
    .div_q(div_q), .dly_q(dly_q), .ien_q(ien_q), .derr_q(derr_q)
  );

  fsc_timer #(.DIV_W(DIV_W), .DLY_W(DLY_W), .OP_TICKS(OP_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .launch(launch), .div_q(div_q), .dly_q(dly_q),
    .busy(busy), .phase(phase)
  );

  // active slot: captured from the buffer on launch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (launch) act_q <= head;
  end

  assign cpu_hold  = req_valid & busy;
  assign irq       = ien_q & ~buf_full;
  assign fl_active = busy;
  assign fl_run    = (phase == PH_OP);
  assign fl_erase  = act_q.erase;
  assign fl_addr   = act_q.addr;
  assign fl_data   = act_q.data;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int DIV_W = 5,
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             buf_full,
  input logic             derr,
  input logic [DIV_W-1:0] div_q,
  input logic [DLY_W-1:0] dly_q,
  input logic             cpu_hold,
  input logic             irq
);
  logic clr_w;
  assign clr_w = bus_sel && bus_we && (bus_addr == 2'd0) && bus_wdata[2];

  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !req_ready);
  p_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !buf_full);
  p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> derr);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (derr && !clr_w) |=> derr);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hold |-> (busy && req_valid));
  p_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(div_q) && $stable(dly_q)));
  p_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && buf_full) |=> (busy && !buf_full));
  p_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(buf_full));
endmodule

bind flash_seq_ctrl fsc_checker #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .req_valid(req_valid),
  .req_ready(req_ready), .busy(busy), .buf_full(buf_full), .derr(derr_q),
  .div_q(div_q), .dly_q(dly_q), .cpu_hold(cpu_hold), .irq(irq)
);

// File: tb/flash_seq_ctrl_tb.sv
`timescale 1ns/1ps
module flash_seq_ctrl_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 0, bus_we = 0;
  logic [1:0]  bus_addr = 0;
  logic [7:0]  bus_wdata = 0, bus_rdata;
  logic        req_valid = 0, req_ready, req_erase = 0;
  logic [15:0] req_addr = 0, req_data = 0;
  logic        cpu_hold, irq, fl_active, fl_run, fl_erase;
  logic [15:0] fl_addr, fl_data;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  flash_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_erase(req_erase),
    .req_addr(req_addr), .req_data(req_data), .cpu_hold(cpu_hold), .irq(irq),
    .fl_active(fl_active), .fl_run(fl_run), .fl_erase(fl_erase),
    .fl_addr(fl_addr), .fl_data(fl_data)
  );

  function automatic int exp_busy(int d, int s);
    return (d + 1) * (s + 1 + 8);
  endfunction
  function automatic int exp_run(int d);
    return 8 * (d + 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 v = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic send(input logic e, input logic [15:0] a, input logic [15:0] d);
    req_valid = 1; req_erase = e; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    int bc, rc;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(2'd1, v); chk("R1 psc", v, 8'h04);
    rd(2'd2, v); chk("R1 dly", v, 8'h18);
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 ready", req_ready, 1'b1);
    chk("R1 active", fl_active, 1'b0);

    // R7 reserved bits
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R7 psc mask", v, 8'h1F);

    // R3 interrupt with enable
    chk("R3 irq off", irq, 1'b0);
    wr(2'd0, 8'h08); chk("R3 irq on", irq, 1'b1);

    // random operations: R2, R9, R10
    for (int i = 0; i < 6; i++) begin
      int d, s;
      logic e;
      logic [15:0] a, dt;
      d = $urandom % 4; s = $urandom % 10;
      e = 1'($urandom % 2); a = 16'($urandom); dt = 16'($urandom);
      wr(2'd1, 8'(d)); wr(2'd2, 8'(s));
      send(e, a, dt);
      rd(2'd0, v); chk("R2 full set", v, 8'h0A);
      chk("R2 not ready", req_ready, 1'b0);
      chk("R3 irq full", irq, 1'b0);
      @(negedge clk);
      rd(2'd0, v); chk("R10 launch", v, 8'h09);
      chk("R10 addr", fl_addr, a);
      chk("R10 data", fl_data, dt);
      chk("R10 kind", fl_erase, e);
      bc = 0; rc = 0;
      while (fl_active) begin
        bc++;
        if (fl_run) rc++;
        @(negedge clk);
      end
      chk("R9 busy len", bc, exp_busy(d, s));
      chk("R9 run len", rc, exp_run(d));
    end

    // directed: overrun, hold, lock, clear, queued start
    wr(2'd1, 8'h01); wr(2'd2, 8'h02);
    send(1'b0, 16'hA001, 16'h1111);
    send(1'b0, 16'hB002, 16'h2222);           // buffer full -> dropped
    rd(2'd0, v); chk("R4 derr set", v, 8'h0D);
    chk("R4 B dropped", fl_addr, 16'hA001);
    req_valid = 1; req_erase = 1; req_addr = 16'hC003; req_data = 16'h3333;
    #1 chk("R6 hold", cpu_hold, 1'b1);
    @(negedge clk); req_valid = 0;
    rd(2'd0, v); chk("R2 full busy", v, 8'h0F);
    chk("R3 irq full busy", irq, 1'b0);
    wr(2'd1, 8'h1F); rd(2'd1, v); chk("R8 psc locked", v, 8'h01);
    wr(2'd2, 8'h55); rd(2'd2, v); chk("R8 dly locked", v, 8'h02);
    wr(2'd0, 8'h08); rd(2'd0, v); chk("R5 w0 no effect", v, 8'h0F);
    req_valid = 1; req_addr = 16'hD004;       // overrun with same-cycle clear
    wr(2'd0, 8'h0C);
    req_valid = 0;
    rd(2'd0, v); chk("R5 set wins", v, 8'h0F);
    while (fl_active) @(negedge clk);
    rd(2'd0, v); chk("R11 gap", v, 8'h0E);
    @(negedge clk);
    chk("R11 queued start", fl_active, 1'b1);
    chk("R11 queued addr", fl_addr, 16'hC003);
    wr(2'd0, 8'h0C); rd(2'd0, v); chk("R5 w1 clear", v, 8'h09);
    while (fl_active) @(negedge clk);
    rd(2'd0, v); chk("R1 idle again", v, 8'h08);
    chk("R3 irq ready", irq, 1'b1);

    done = 1'b1;
    finish_run();
  end
endmodule